// File: doc/BRIEF.md
# Zone-Protected TLB Address Translator

This block turns a 32-bit effective address into a physical address by searching a fully associative table of software-loaded translation entries. Each entry holds an effective page number, a real page number, a page-size code, a process tag, a valid bit, an execute-enable bit, a write-enable bit and an 8-bit attribute byte. A tag match alone is not enough to grant an access. The upper attribute nibble picks one of sixteen two-bit codes from a zone register. That code either grants everything, denies user accesses, or leaves the decision to the entry's own execute and write bits.

Lookups enter on a valid/ready request channel and leave on a valid/ready response channel. The request is taken when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the response register is empty or is being drained in the same cycle. The response appears one clock after acceptance. It holds steady while `rsp_ready` is low. Entries are loaded through a plain write port with no handshake.

Top module: `zone_tlb_xlate`

## Requirements
- R1: An entry whose valid bit is clear never matches. After reset every entry is invalid and `rsp_valid` is low.
- R2: An entry with process tag 0 matches any `cur_pid`. Any other tag matches only when it equals `cur_pid`.
- R3: Size code c (0..7) gives a page of 2^(10+2c) bytes. An entry matches when the address bits above the page offset equal the same bits of its stored page number.
- R4: On a grant, `rsp_paddr` takes the real page number bits above the page offset and the request address bits inside the offset.
- R5: Attribute bits [7:4] select zone z. Its code is `zone_reg[31-2z:30-2z]`, so zone 0 is the top two bits.
- R6: Zone code 0 denies every user-mode access (`req_user`=1). In supervisor mode it behaves like codes 1 and 2.
- R7: Under codes 1 and 2, a fetch needs the execute bit and a data store needs the write bit. A granted access reports read permission, plus write permission when the entry's write bit is set.
- R8: Zone code 3 grants every access and reports both read and write permission.
- R9: Entries are tried from index 0 upward. A matching entry that denies does not end the search. The lowest-indexed granting entry wins and its index is reported on `rsp_index`.
- R10: `rsp_kind` is 0 for a grant and 1 when some entry matched but none granted (`rsp_hit`=1). It is 2 for an instruction-fetch miss and 3 for a data miss (`rsp_hit`=0).
- R11: On a miss, `rsp_dear` is the request address. `rsp_esr` is 0x00800000 for a data store and 0 for a data load or a fetch.
- R12: The response comes one cycle after acceptance. While `rsp_ready` is low it holds unchanged and `req_ready` is low.
- R13: A table write takes effect in the cycle after `wr_en`. A lookup accepted in the same cycle as the write sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be taken |
| req_addr | input | 32 | Effective address |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| req_store | input | 1 | Data store (ignored for fetches) |
| req_user | input | 1 | User-mode access |
| cur_pid | input | 8 | Current process tag |
| zone_reg | input | 32 | Sixteen two-bit zone codes |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_hit | output | 1 | At least one entry matched |
| rsp_grant | output | 1 | Access granted |
| rsp_kind | output | 2 | Result class (R10) |
| rsp_paddr | output | 32 | Physical address (0 unless granted) |
| rsp_perm_r | output | 1 | Read permission granted |
| rsp_perm_w | output | 1 | Write permission granted |
| rsp_index | output | 6 | Index of the granting entry |
| rsp_dear | output | 32 | Faulting address on a miss |
| rsp_esr | output | 32 | Syndrome value on a miss |
| wr_en | input | 1 | Write one entry |
| wr_idx | input | 6 | Entry to write |
| wr_vld | input | 1 | Valid bit to store |
| wr_pid | input | 8 | Process tag to store |
| wr_epn | input | 32 | Effective page number (offset bits dropped) |
| wr_rpn | input | 32 | Real page number |
| wr_size | input | 3 | Page-size code |
| wr_xe | input | 1 | Execute enable |
| wr_we | input | 1 | Write enable |
| wr_attr | input | 8 | Attribute byte, zone in [7:4] |

## Verification
The hardest case to reach is a lookup where several entries match but the earlier ones deny. In that case the search must step past them without reporting a fault. The bench loads two entries with the same page in different zones. It then issues a store, which the lower entry's write bit refuses, and a load, which the lower entry accepts, and checks which index wins each time. The second hard case is a table write in the same cycle as an accepted lookup. The bench drives both on one edge and expects the old contents before the new ones.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
  localparam int ADDR_W = 32;
  localparam int PID_W  = 8;

  typedef struct packed {
    logic              vld;
    logic [PID_W-1:0]  pid;
    logic [ADDR_W-1:0] epn;
    logic [ADDR_W-1:0] rpn;
    logic [2:0]        szc;
    logic              xe;
    logic              we;
    logic [7:0]        attr;
  } tlbx_ent_t;

  typedef enum logic [1:0] {
    RES_GRANT = 2'd0,
    RES_PROT  = 2'd1,
    RES_IMISS = 2'd2,
    RES_DMISS = 2'd3
  } tlbx_res_e;

  // keep mask: ones above the page offset
  function automatic logic [ADDR_W-1:0] page_mask(input logic [2:0] szc);
    logic [4:0] bits;
    bits = 5'd10 + {1'b0, szc, 1'b0};
    return ~((ADDR_W'(1) << bits) - ADDR_W'(1));
  endfunction
endpackage

// File: rtl/tlbx_store.sv
module tlbx_store
  import tlbx_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  logic [IW-1:0] wr_idx,
  input  tlbx_ent_t wr_ent,
  output tlbx_ent_t ents [ENTRIES]
);
  tlbx_ent_t tbl [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
    end else if (wr_en) begin
      tbl[wr_idx]     <= wr_ent;
      tbl[wr_idx].epn <= wr_ent.epn & page_mask(wr_ent.szc);
    end
  end

  assign ents = tbl;

  p_write_lands_r13: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (tbl[$past(wr_idx)].vld == $past(wr_ent.vld)));
endmodule

// File: rtl/tlbx_check.sv
module tlbx_check
  import tlbx_pkg::*;
(
  input  tlbx_ent_t         ent,
  input  logic [ADDR_W-1:0] addr,
  input  logic              fetch,
  input  logic              store,
  input  logic              user,
  input  logic [PID_W-1:0]  pid,
  input  logic [31:0]       zone_reg,
  output logic              match,
  output logic              grant,
  output logic              perm_w
);
  logic [ADDR_W-1:0] m;
  logic [4:0]        sh;
  logic [1:0]        code;
  logic              own_ok;

  always_comb begin
    m     = page_mask(ent.szc);
    match = ent.vld && (ent.pid == '0 || ent.pid == pid) && ((addr & m) == ent.epn);
    sh    = 5'd30 - {ent.attr[7:4], 1'b0};
    code  = 2'(zone_reg >> sh);
    if (fetch)      own_ok = ent.xe;
    else if (store) own_ok = ent.we;
    else            own_ok = 1'b1;
    grant  = 1'b0;
    perm_w = 1'b0;
    if (match) begin
      unique case (code)
        2'd3: begin grant = 1'b1; perm_w = 1'b1; end
        2'd0: begin grant = !user && own_ok; perm_w = grant && ent.we; end
        default: begin grant = own_ok; perm_w = own_ok && ent.we; end
      endcase
    end
  end

  always_comb begin
    if (grant) p_grant_is_match_r1: assert (match);
  end
endmodule

// File: rtl/tlbx_pick.sv
module tlbx_pick #(
  parameter int ENTRIES = 64,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] match,
  input  logic [ENTRIES-1:0] grant,
  output logic               any_match,
  output logic               found,
  output logic [IW-1:0]      idx
);
  always_comb begin
    any_match = |match;
    found     = |grant;
    idx       = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (grant[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/zone_tlb_xlate.sv
module zone_tlb_xlate
  import tlbx_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_addr,
  input  logic              req_fetch,
  input  logic              req_store,
  input  logic              req_user,
  input  logic [7:0]        cur_pid,
  input  logic [31:0]       zone_reg,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic              rsp_grant,
  output logic [1:0]        rsp_kind,
  output logic [31:0]       rsp_paddr,
  output logic              rsp_perm_r,
  output logic              rsp_perm_w,
  output logic [IW-1:0]     rsp_index,
  output logic [31:0]       rsp_dear,
  output logic [31:0]       rsp_esr,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic              wr_vld,
  input  logic [7:0]        wr_pid,
  input  logic [31:0]       wr_epn,
  input  logic [31:0]       wr_rpn,
  input  logic [2:0]        wr_size,
  input  logic              wr_xe,
  input  logic              wr_we,
  input  logic [7:0]        wr_attr
);
  localparam logic [31:0] STORE_SYND = 32'h0080_0000;

  tlbx_ent_t          ents [ENTRIES];
  tlbx_ent_t          wr_ent;
  logic [ENTRIES-1:0] e_match, e_grant, e_pw;
  logic               any_match, found;
  logic [IW-1:0]      pick;

  assign wr_ent = '{vld: wr_vld, pid: wr_pid, epn: wr_epn, rpn: wr_rpn,
                    szc: wr_size, xe: wr_xe, we: wr_we, attr: wr_attr};

  tlbx_store #(.ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_ent(wr_ent), .ents(ents)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    tlbx_check u_chk (
      .ent(ents[g]), .addr(req_addr), .fetch(req_fetch), .store(req_store),
      .user(req_user), .pid(cur_pid), .zone_reg(zone_reg),
      .match(e_match[g]), .grant(e_grant[g]), .perm_w(e_pw[g])
    );
  end

  tlbx_pick #(.ENTRIES(ENTRIES)) u_pick (
    .match(e_match), .grant(e_grant), .any_match(any_match),
    .found(found), .idx(pick)
  );

  // next response
  logic [31:0] n_paddr, n_dear, n_esr, pm;
  tlbx_res_e   n_kind;

  always_comb begin
    pm      = page_mask(ents[pick].szc);
    n_paddr = '0;
    n_dear  = '0;
    n_esr   = '0;
    if (found) begin
      n_kind  = RES_GRANT;
      n_paddr = (ents[pick].rpn & pm) | (req_addr & ~pm);
    end else if (any_match) begin
      n_kind = RES_PROT;
    end else begin
      n_kind = req_fetch ? RES_IMISS : RES_DMISS;
      n_dear = req_addr;
      n_esr  = (!req_fetch && req_store) ? STORE_SYND : '0;
    end
  end

  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_grant  <= 1'b0;
      rsp_kind   <= RES_GRANT;
      rsp_paddr  <= '0;
      rsp_perm_r <= 1'b0;
      rsp_perm_w <= 1'b0;
      rsp_index  <= '0;
      rsp_dear   <= '0;
      rsp_esr    <= '0;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit    <= any_match;
        rsp_grant  <= found;
        rsp_kind   <= n_kind;
        rsp_paddr  <= n_paddr;
        rsp_perm_r <= found;
        rsp_perm_w <= found && e_pw[pick];
        rsp_index  <= found ? pick : '0;
        rsp_dear   <= n_dear;
        rsp_esr    <= n_esr;
      end
    end
  end

  p_rsp_follows_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
  p_rsp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_kind) && $stable(rsp_paddr)
                                   && $stable(rsp_index)));
  p_grant_needs_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_grant) |-> (rsp_hit && rsp_kind == RES_GRANT));
  p_miss_kind_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (!rsp_grant && rsp_kind[1]));
  p_fetch_syndrome_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == RES_IMISS) |-> (rsp_esr == '0));
  p_write_needs_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_perm_w) |-> rsp_perm_r);
endmodule

// File: tb/tb_zone_tlb_xlate.sv
module tb_zone_tlb_xlate;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic req_valid = 0, req_ready, req_fetch = 0, req_store = 0, req_user = 0;
  logic [31:0] req_addr = 0, zone_reg = 0;
  logic [7:0] cur_pid = 0;
  logic rsp_valid, rsp_ready = 1, rsp_hit, rsp_grant, rsp_perm_r, rsp_perm_w;
  logic [1:0] rsp_kind;
  logic [31:0] rsp_paddr, rsp_dear, rsp_esr;
  logic [5:0] rsp_index;
  logic wr_en = 0, wr_vld = 0, wr_xe = 0, wr_we = 0;
  logic [5:0] wr_idx = 0;
  logic [7:0] wr_pid = 0, wr_attr = 0;
  logic [31:0] wr_epn = 0, wr_rpn = 0;
  logic [2:0] wr_size = 0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  zone_tlb_xlate dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input bit v, input logic [7:0] pid,
                    input logic [31:0] epn, input logic [31:0] rpn, input logic [2:0] sz,
                    input bit xe, input bit we, input logic [7:0] attr);
    @(negedge clk);
    wr_en = 1; wr_idx = 6'(idx); wr_vld = v; wr_pid = pid; wr_epn = epn; wr_rpn = rpn;
    wr_size = sz; wr_xe = xe; wr_we = we; wr_attr = attr;
    @(negedge clk);
    wr_en = 0;
  endtask

  // drive at negedge, accept at posedge, sample at next negedge
  task automatic look(input logic [31:0] a, input bit f, input bit s, input bit u,
                      input logic [7:0] pid, input logic [31:0] z);
    @(negedge clk);
    req_addr = a; req_fetch = f; req_store = s; req_user = u; cur_pid = pid; zone_reg = z;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic expect_grant(string tag, logic [31:0] pa, bit pw, int idx);
    chk({tag, " kind"}, 32'(rsp_kind), 0);
    chk({tag, " grant"}, 32'(rsp_grant), 1);
    chk({tag, " paddr"}, rsp_paddr, pa);
    chk({tag, " perm_w"}, 32'(rsp_perm_w), 32'(pw));
    chk({tag, " index"}, 32'(rsp_index), 32'(idx));
  endtask

  task automatic t_reset;
    chk("R1 reset rsp_valid", 32'(rsp_valid), 0);
    chk("R12 reset req_ready", 32'(req_ready), 1);
    look(32'h1000_0ABC, 0, 0, 0, 0, 32'hFFFF_FFFF);
    chk("R1 empty table kind", 32'(rsp_kind), 3);
    chk("R1 empty table hit", 32'(rsp_hit), 0);
  endtask

  task automatic t_basic;
    wr(5, 1, 0, 32'h1000_0000, 32'h8000_0000, 3'd1, 1, 1, 8'h00);
    look(32'h1000_0ABC, 0, 0, 1, 8'h33, 32'h4000_0000);
    chk("R12 rsp_valid after accept", 32'(rsp_valid), 1);
    expect_grant("R4 basic", 32'h8000_0ABC, 1, 5);
    look(32'h1000_1ABC, 0, 0, 1, 0, 32'h4000_0000);
    chk("R3 outside 4KB page", 32'(rsp_kind), 3);
    wr(6, 1, 0, 32'h2000_0000, 32'h3012_3456, 3'd3, 1, 1, 8'h00);
    look(32'h2000_BEEF, 0, 0, 0, 0, 32'h4000_0000);
    expect_grant("R3 64KB page", 32'h3012_BEEF, 1, 6);
    wr(5, 0, 0, 32'h1000_0000, 32'h8000_0000, 3'd1, 1, 1, 8'h00);
    look(32'h1000_0ABC, 0, 0, 0, 0, 32'h4000_0000);
    chk("R1 invalid entry kind", 32'(rsp_kind), 3);
    chk("R1 invalid entry hit", 32'(rsp_hit), 0);
  endtask

  task automatic t_pid;
    wr(7, 1, 8'h12, 32'h4000_0000, 32'h5000_0000, 3'd1, 1, 1, 8'h10);
    look(32'h4000_0010, 0, 0, 1, 8'h12, 32'h1000_0000);
    expect_grant("R2 pid equal", 32'h5000_0010, 1, 7);
    look(32'h4000_0010, 0, 0, 1, 8'h13, 32'h1000_0000);
    chk("R2 pid differs kind", 32'(rsp_kind), 3);
  endtask

  task automatic t_zones;
    wr(8, 1, 0, 32'h6000_0000, 32'h6100_0000, 3'd1, 0, 0, 8'h10);
    look(32'h6000_0044, 0, 1, 1, 0, 32'h3000_0000);
    expect_grant("R8 code3 store", 32'h6100_0044, 1, 8);
    chk("R5 R8 perm_r", 32'(rsp_perm_r), 1);
    look(32'h6000_0044, 0, 1, 1, 0, 32'h1000_0000);
    chk("R7 store no we kind", 32'(rsp_kind), 1);
    chk("R7 store no we hit", 32'(rsp_hit), 1);
    look(32'h6000_0044, 1, 0, 1, 0, 32'h2000_0000);
    chk("R7 fetch no xe kind", 32'(rsp_kind), 1);
    look(32'h6000_0044, 0, 0, 1, 0, 32'h1000_0000);
    expect_grant("R7 load read only", 32'h6100_0044, 0, 8);
    look(32'h6000_0044, 0, 0, 1, 0, 32'h0300_0000);
    chk("R5 wrong zone bits code0 user", 32'(rsp_kind), 1);
    wr(9, 1, 0, 32'h7000_0000, 32'h7700_0000, 3'd1, 1, 1, 8'h20);
    look(32'h7000_0008, 0, 0, 1, 0, 32'hF3FF_FFFF);
    chk("R6 code0 user denied", 32'(rsp_kind), 1);
    look(32'h7000_0008, 0, 0, 0, 0, 32'hF3FF_FFFF);
    expect_grant("R6 code0 supervisor load", 32'h7700_0008, 1, 9);
    look(32'h7000_0008, 1, 0, 0, 0, 32'hF3FF_FFFF);
    expect_grant("R6 code0 supervisor fetch", 32'h7700_0008, 1, 9);
  endtask

  task automatic t_priority;
    wr(10, 1, 0, 32'h9000_0000, 32'hA000_0000, 3'd1, 1, 0, 8'h30);
    wr(11, 1, 0, 32'h9000_0000, 32'hB000_0000, 3'd1, 1, 1, 8'h40);
    look(32'h9000_0123, 0, 1, 1, 0, 32'h0140_0000);
    expect_grant("R9 skip denying entry", 32'hB000_0123, 1, 11);
    look(32'h9000_0123, 0, 0, 1, 0, 32'h0140_0000);
    expect_grant("R9 lowest granting wins", 32'hA000_0123, 0, 10);
  endtask

  task automatic t_miss;
    look(32'hDEAD_B000, 1, 1, 0, 0, 0);
    chk("R10 fetch miss kind", 32'(rsp_kind), 2);
    chk("R11 fetch miss dear", rsp_dear, 32'hDEAD_B000);
    chk("R11 fetch miss esr", rsp_esr, 0);
    look(32'hDEAD_C004, 0, 1, 0, 0, 0);
    chk("R10 store miss kind", 32'(rsp_kind), 3);
    chk("R11 store miss esr", rsp_esr, 32'h0080_0000);
    chk("R11 store miss dear", rsp_dear, 32'hDEAD_C004);
    look(32'hDEAD_C008, 0, 0, 0, 0, 0);
    chk("R11 load miss esr", rsp_esr, 0);
  endtask

  task automatic t_backpressure;
    @(negedge clk); rsp_ready = 0;
    look(32'h2000_0001, 0, 0, 0, 0, 32'h4000_0000);
    repeat (2) @(negedge clk);
    chk("R12 held valid", 32'(rsp_valid), 1);
    chk("R12 held paddr", rsp_paddr, 32'h3012_0001);
    chk("R12 req_ready low", 32'(req_ready), 0);
    rsp_ready = 1;
    @(negedge clk);
    chk("R12 drained", 32'(rsp_valid), 0);
  endtask

  task automatic t_write_same_cycle;
    @(negedge clk);
    wr_en = 1; wr_idx = 12; wr_vld = 1; wr_pid = 0; wr_epn = 32'hC000_0000;
    wr_rpn = 32'hCC00_0000; wr_size = 1; wr_xe = 1; wr_we = 1; wr_attr = 8'h00;
    req_addr = 32'hC000_0010; req_fetch = 0; req_store = 0; req_user = 0;
    zone_reg = 32'h4000_0000; req_valid = 1;
    @(negedge clk);
    wr_en = 0; req_valid = 0;
    chk("R13 old contents seen", 32'(rsp_kind), 3);
    look(32'hC000_0010, 0, 0, 0, 0, 32'h4000_0000);
    expect_grant("R13 new entry next", 32'hCC00_0010, 1, 12);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_pre: begin end
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_pid();
    t_zones();
    t_priority();
    t_miss();
    t_backpressure();
    t_write_same_cycle();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule